// File: doc/BRIEF.md
# Serial Address/Data Register Programming Port

This block is a three-wire programming port that lets a host processor load a small bank of 16-bit control registers over a slow serial link made of a serial clock, a serial data line and an enable line. All three wires are brought into the fast system clock domain through two-flop synchronizers. Bits are taken on rising serial clock edges, most significant bit first, into one shared shift path.

The enable level decides what a group of serial clocks means. With enable high, the clocked bits form an 8-bit register address, which is captured when enable falls. With enable low, they form a 16-bit data word, which is written into the register selected by the stored address when enable rises. A host that sends whole bytes may put don't-care bits ahead of a word, because only the most recent 8 or 16 bits are used.

A status output tells the host whether every register still holds its power-up default. After a glitch has reset the bank, the host sees the flag and reloads its settings. Loading is never gated by any operating mode.

Top module: `sprog_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, register i of the bank holds 16'h1A30 + 16'h0111*i (i = 0..5), and `status_def` is 1.
- R2: Serial clocks that arrive while `ser_en` is high shift an address. When `ser_en` falls, the last 8 bits, first bit as MSB, become the current address. The address register resets to 0.
- R3: Serial clocks that arrive while `ser_en` is low shift data. When `ser_en` rises, the last 16 bits, first bit as MSB, are written into the register at the current address. Register i appears at `regs_flat[16*i+15:16*i]`.
- R4: Any number of extra leading bits sent before an address or data word has no effect. Only the final 8 or 16 bits are used.
- R5: `status_def` is 0 whenever any register differs from its default. It returns to 1 once every register again holds its default value, including when the default values are written back over the serial port.
- R6: A data write to an address of 6 or above changes no register.
- R7: An edge of `ser_en` with no serial clock since the previous opposite edge latches nothing. A rise writes no register, and a fall leaves the address unchanged.
- R8: Only rising serial clock edges shift bits in. The serial clock may rest high or low around enable transitions, and its falling edges have no effect.
- R9: Asserting `rst` after registers have been written restores every default, returns `status_def` to 1 and resets the address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up or glitch) |
| ser_clk | input | 1 | Asynchronous serial clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Asynchronous serial data, MSB first |
| ser_en | input | 1 | Asynchronous enable; high selects address shifting, low selects data shifting |
| regs_flat | output | 96 | Contents of the six 16-bit registers, register i at bits 16*i+15..16*i |
| status_def | output | 1 | 1 when every register holds its power-up default |

## Verification
The bench sends words with 0 to 8 don't-care prefix bits. A design that used the first bits received instead of the last would land data at the wrong place. It writes to an unimplemented address, where a design that drops the range check would alias the write onto a real register. It pulses enable with no clocks between edges, which a design without pending tracking would turn into a spurious address or data latch. It runs sequences with the serial clock idling high, where a design that shifted on both edges would double bits. It also writes the defaults back one register at a time and pulses reset, so a status flag that is sticky, or that only follows reset, shows the wrong level.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 6;
    localparam int SYNC_N   = 2;

    localparam logic [DATA_W-1:0] DEF_BASE = 16'h1A30;
    localparam logic [DATA_W-1:0] DEF_STEP = 16'h0111;

    typedef enum logic { MODE_DATA = 1'b0, MODE_ADDR = 1'b1 } shift_mode_e;

    typedef struct packed {
        logic sclk_rise;
        logic sdat;
        logic en_lvl;
        logic en_rise;
        logic en_fall;
    } ser_evt_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        return DEF_BASE + DATA_W'(idx) * DEF_STEP;
    endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync
    import sprog_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     ser_dat,
    input  logic     ser_en,
    output ser_evt_t evt
);
    localparam int NW = 3;

    logic [NW-1:0] raw;
    logic [NW-1:0] stg_q [STAGES];
    logic [NW-1:0] last_q;
    logic [NW-1:0] lvl;

    assign raw = {ser_en, ser_dat, ser_clk};

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q[s] <= '0;
                end else if (s == 0) begin
                    stg_q[s] <= raw;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign lvl = stg_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= lvl;
    end

    always_comb begin
        evt.sclk_rise = lvl[0] & ~last_q[0];
        evt.sdat      = lvl[1];
        evt.en_lvl    = lvl[2];
        evt.en_rise   = lvl[2] & ~last_q[2];
        evt.en_fall   = ~lvl[2] & last_q[2];
    end

endmodule

// File: rtl/sprog_frontend.sv
module sprog_frontend
    import sprog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t evt,
    output wr_req_t  wr
);
    logic [DATA_W-1:0] shift_q;
    logic [ADDR_W-1:0] addr_q;
    logic              apend_q;
    logic              dpend_q;
    shift_mode_e       mode;

    assign mode = evt.en_lvl ? MODE_ADDR : MODE_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            addr_q  <= '0;
            apend_q <= 1'b0;
            dpend_q <= 1'b0;
        end else begin
            if (evt.sclk_rise) begin
                shift_q <= {shift_q[DATA_W-2:0], evt.sdat};
                if (mode == MODE_ADDR) apend_q <= 1'b1;
                else                   dpend_q <= 1'b1;
            end
            if (evt.en_fall) begin
                if (apend_q) addr_q <= shift_q[ADDR_W-1:0];
                apend_q <= 1'b0;
            end
            if (evt.en_rise) begin
                dpend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        wr.en   = evt.en_rise & dpend_q;
        wr.addr = addr_q;
        wr.data = shift_q;
    end

    // R2: the address only moves after an enable fall that followed address clocks
    a_r2_addr_on_fall: assert property (@(posedge clk) disable iff (rst)
        (addr_q != $past(addr_q)) |-> $past(evt.en_fall && apend_q));

    // R8: the shift path holds still unless a rising serial clock was seen
    a_r8_shift_on_rise: assert property (@(posedge clk) disable iff (rst)
        !evt.sclk_rise |=> $stable(shift_q));

endmodule

// File: rtl/sprog_regbank.sv
module sprog_regbank
    import sprog_pkg::*;
#(
    parameter int NREG = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   status_def
);
    localparam logic [ADDR_W:0] NREG_L = (ADDR_W+1)'(NREG);

    logic [DATA_W-1:0] regs_q [NREG];
    logic              in_range;

    assign in_range = ({1'b0, wr.addr} < NREG_L);

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= reg_default(i);
                end else if (wr.en && in_range && wr.addr == ADDR_W'(i)) begin
                    regs_q[i] <= wr.data;
                end
            end
            assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
        end
    endgenerate

    always_comb begin
        status_def = 1'b1;
        for (int k = 0; k < NREG; k++) begin
            if (regs_q[k] != reg_default(k)) status_def = 1'b0;
        end
    end

    // R1: one cycle after reset the bank reads as defaults
    a_r1_reset_defaults: assert property (@(posedge clk)
        $past(rst) |-> status_def);

    // R6: a register changes only after a write aimed at an implemented address
    a_r6_ignore_unimpl: assert property (@(posedge clk) disable iff (rst)
        (regs_flat != $past(regs_flat)) |-> $past(wr.en && in_range));

    // R5: status drops only when some register changed
    a_r5_status_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(status_def) |-> (regs_flat != $past(regs_flat)));

endmodule

// File: rtl/sprog_port.sv
module sprog_port
    import sprog_pkg::*;
#(
    parameter int NREG   = NUM_REGS,
    parameter int STAGES = SYNC_N
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_dat,
    input  logic                   ser_en,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   status_def
);
    ser_evt_t evt;
    wr_req_t  wr;

    sprog_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_en  (ser_en),
        .evt     (evt)
    );

    sprog_frontend u_front (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .wr  (wr)
    );

    sprog_regbank #(.NREG(NREG)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .regs_flat  (regs_flat),
        .status_def (status_def)
    );

    // R3: a write strobe needs enable to have just gone high
    a_r3_write_on_rise: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (evt.en_lvl && !$past(evt.en_lvl)));

endmodule

// File: tb/sim_sprog_port.sv
module sim_sprog_port;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  pre;
        logic        idle_hi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 16'hBEEF, 4'd0, 1'b0},
        '{8'd3, 16'h1234, 4'd8, 1'b0},
        '{8'd5, 16'h0001, 4'd3, 1'b0},
        '{8'd9, 16'hFFFF, 4'd0, 1'b0},
        '{8'd0, 16'h1A30, 4'd0, 1'b0},
        '{8'd3, 16'h1D63, 4'd5, 1'b1},
        '{8'd5, 16'h1F85, 4'd0, 1'b0},
        '{8'd2, 16'h8000, 4'd1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b0;
    logic [95:0] regs_flat;
    logic        status_def;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [6];

    always #2 clk = ~clk;

    sprog_port u0 (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .ser_en     (ser_en),
        .regs_flat  (regs_flat),
        .status_def (status_def)
    );

    function automatic logic [15:0] dflt(input int i);
        return 16'h1A30 + 16'h0111 * 16'(i);
    endfunction

    function automatic logic [95:0] model_flat();
        logic [95:0] f;
        for (int i = 0; i < 6; i++) f[i*16 +: 16] = model[i];
        return f;
    endfunction

    function automatic logic model_status();
        for (int i = 0; i < 6; i++) if (model[i] != dflt(i)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic hi);
        if (hi) begin
            ser_clk = 1'b0; ser_dat = b; wt(4);
            ser_clk = 1'b1; wt(4);
        end else begin
            ser_dat = b; wt(4);
            ser_clk = 1'b1; wt(4);
            ser_clk = 1'b0; wt(4);
        end
    endtask

    task automatic send_addr(input logic [7:0] a, input int pre, input logic hi);
        ser_en = 1'b1; wt(6);
        for (int k = 0; k < pre; k++) send_bit(k[0], hi);
        for (int k = 7; k >= 0; k--) send_bit(a[k], hi);
        ser_en = 1'b0; wt(6);
    endtask

    task automatic send_data(input logic [15:0] d, input int pre, input logic hi);
        for (int k = 0; k < pre; k++) send_bit(~k[0], hi);
        for (int k = 15; k >= 0; k--) send_bit(d[k], hi);
        ser_en = 1'b1; wt(6);
        ser_en = 1'b0; wt(6);
        if (hi) begin ser_clk = 1'b0; wt(4); end
        wt(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) model[i] = dflt(i);
        wt(5);
        // R1: defaults during reset
        chk("R1 regs in reset", {32'b0, regs_flat}, {32'b0, model_flat()});
        chk("R1 status in reset", {127'b0, status_def}, 128'd1);
        rst = 1'b0;
        wt(4);

        // R2 R3 R4 R5 R6 R8: table walk
        for (int v = 0; v < NV; v++) begin
            send_addr(VECS[v].addr, int'(VECS[v].pre), VECS[v].idle_hi);
            send_data(VECS[v].data, int'(VECS[v].pre), VECS[v].idle_hi);
            if (VECS[v].addr < 8'd6) model[VECS[v].addr] = VECS[v].data;
            chk($sformatf("R2/R3/R4/R6/R8 vec%0d regs", v), {32'b0, regs_flat}, {32'b0, model_flat()});
            chk($sformatf("R5 vec%0d status", v), {127'b0, status_def}, {127'b0, model_status()});
        end

        // R7: enable pulse with no clocks latches nothing
        ser_en = 1'b1; wt(8);
        ser_en = 1'b0; wt(8);
        chk("R7 bare enable pulse regs", {32'b0, regs_flat}, {32'b0, model_flat()});
        send_data(16'h5A5A, 0, 1'b0);
        model[2] = 16'h5A5A;
        chk("R7 address kept after bare pulse", {32'b0, regs_flat}, {32'b0, model_flat()});

        // R9: reset after writes
        @(negedge clk); rst = 1'b1; wt(3); rst = 1'b0; wt(2);
        for (int i = 0; i < 6; i++) model[i] = dflt(i);
        chk("R9 regs after reset", {32'b0, regs_flat}, {32'b0, model_flat()});
        chk("R9 status after reset", {127'b0, status_def}, 128'd1);
        // R9: address back to 0, a data-only write lands in register 0
        send_data(16'h0F0F, 0, 1'b0);
        model[0] = 16'h0F0F;
        chk("R9 address reset to 0", {32'b0, regs_flat}, {32'b0, model_flat()});
        chk("R5 status after write", {127'b0, status_def}, 128'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule